// File: doc/BRIEF.md
# Instruction Fetch Stage with Fetch/Decode Register

This block is the front end of a five-stage 32-bit RISC pipeline. It keeps a 10-bit program counter, reads the 32-bit word at that address from a small instruction ROM, and captures the word together with the address of the following instruction in the register that feeds decode. Decode uses that stored address to form branch targets.

The next program counter comes from one of three sources: the sequential address, a branch target or a jump target. Two 2:1 multiplexers are chained to make this choice. A single enable input stalls the stage for a cycle. When enable is low, the program counter and the fetch/decode register both keep their values. A redirect (branch taken or jump) also flushes the fetch/decode register to an all-zero word, which acts as a no-op. This removes the instruction that was fetched on the wrong path.

The ROM contents are defined by a formula with parameters, so no table is stored. Word `k` holds `ROM_BASE + k*ROM_STEP` when `k < ROM_WORDS`, and holds zero otherwise.

Top module: `fetch_stage`

## Requirements
- R1: While `rst_ni` is low, `pc_plus4_o` and `instr_o` read zero at once, without waiting for a clock edge. After reset is released, the first enabled fetch uses address 0.
- R2: On a clock edge with `en_i` high and no redirect, the register captures `pc_plus4_o = pc + 4` and `instr_o = rom(pc)`, and the program counter advances to `pc + 4`.
- R3: On an enabled edge with `branch_taken_i` high and `jump_i` low, the program counter loads `branch_addr_i`.
- R4: On an enabled edge with `jump_i` high, the program counter loads `jump_addr_i`, whatever the value of `branch_taken_i`.
- R5: On any edge where `branch_taken_i` or `jump_i` is high, the fetch/decode register clears to zero. This flush takes effect even when `en_i` is low.
- R6: On an edge with `en_i` low and no redirect, `pc_plus4_o`, `instr_o` and the program counter keep their values. With `en_i` low, the program counter holds even during a redirect.
- R7: The ROM word index is `pc[9:2]`. Word `k` is `ROM_BASE + k*ROM_STEP` (modulo 2^32) for `k < ROM_WORDS`, and 0 for any higher index.
- R8: The program counter is 10 bits and wraps, so 0x3FC + 4 gives address 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Stage enable; low stalls the PC and the register |
| branch_taken_i | input | 1 | Selects the branch target; also flushes the register |
| branch_addr_i | input | 10 | Branch target address |
| jump_i | input | 1 | Selects the jump target (has priority); also flushes the register |
| jump_addr_i | input | 10 | Jump target address |
| pc_plus4_o | output | 10 | Registered address of the instruction after the fetched one |
| instr_o | output | 32 | Registered fetched instruction |

## Verification
The bench builds the block with `ROM_WORDS = 12`, so only words 0 to 11 hold data. With that setting, jumps to 0x100 and to 0x3FC land in the zero region of the ROM, which checks the upper bound of R7. The last slot, 0x3FC, also gives a short path to the wrap-around of R8. `ROM_BASE` and `ROM_STEP` differ from their defaults and are chosen so that neighbouring words differ in both halves. As a result, a wrong word index shows up in the fetched data.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned INSTR_W = 32;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_src_e;

  // Computed ROM contents: linear pattern over filled words, zero above.
  function automatic logic [INSTR_W-1:0] rom_word(input int unsigned idx,
                                                 input int unsigned words,
                                                 input logic [INSTR_W-1:0] base,
                                                 input logic [INSTR_W-1:0] step);
    logic [INSTR_W-1:0] k;
    k = INSTR_W'(idx);
    if (idx < words) return base + k * step;
    return '0;
  endfunction
endpackage

// File: rtl/fetch_next_pc.sv
module fetch_next_pc
  import fetch_pkg::*;
#(
  parameter int unsigned PC_W = 10
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            branch_taken_i,
  input  logic [PC_W-1:0] branch_addr_i,
  input  logic            jump_i,
  input  logic [PC_W-1:0] jump_addr_i,
  output logic [PC_W-1:0] pc_plus4_o,
  output logic [PC_W-1:0] next_pc_o,
  output npc_src_e        src_o
);
  logic [PC_W-1:0] after_branch;

  assign pc_plus4_o   = pc_i + PC_W'(4);
  // first mux: branch target over sequential
  assign after_branch = branch_taken_i ? branch_addr_i : pc_plus4_o;
  // second mux: jump target over everything
  assign next_pc_o    = jump_i ? jump_addr_i : after_branch;

  always_comb begin
    if (jump_i)              src_o = NPC_JUMP;
    else if (branch_taken_i) src_o = NPC_BRANCH;
    else                     src_o = NPC_SEQ;
  end
endmodule

// File: rtl/fetch_rom.sv
module fetch_rom
  import fetch_pkg::*;
#(
  parameter int unsigned       PC_W      = 10,
  parameter int unsigned       ROM_WORDS = 48,
  parameter logic [INSTR_W-1:0] ROM_BASE = 32'h2000_0100,
  parameter logic [INSTR_W-1:0] ROM_STEP = 32'h0004_0003
) (
  input  logic [PC_W-3:0]    word_idx_i,
  output logic [INSTR_W-1:0] data_o
);
  localparam int unsigned DEPTH = 2 ** (PC_W - 2);

  generate
    if (ROM_WORDS >= DEPTH) begin : g_full
      assign data_o = ROM_BASE + INSTR_W'(word_idx_i) * ROM_STEP;
    end else begin : g_partial
      assign data_o = rom_word(int'(word_idx_i), ROM_WORDS, ROM_BASE, ROM_STEP);
    end
  endgenerate
endmodule

// File: rtl/fetch_dec_reg.sv
module fetch_dec_reg #(
  parameter int unsigned WIDTH = 42
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             flush_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (flush_i) q_o <= '0;  // flush beats enable
    else if (en_i)    q_o <= d_i;
  end
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
  import fetch_pkg::*;
#(
  parameter int unsigned        PC_W      = 10,
  parameter int unsigned        ROM_WORDS = 48,
  parameter logic [INSTR_W-1:0] ROM_BASE  = 32'h2000_0100,
  parameter logic [INSTR_W-1:0] ROM_STEP  = 32'h0004_0003
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               branch_taken_i,
  input  logic [PC_W-1:0]    branch_addr_i,
  input  logic               jump_i,
  input  logic [PC_W-1:0]    jump_addr_i,
  output logic [PC_W-1:0]    pc_plus4_o,
  output logic [INSTR_W-1:0] instr_o
);
  localparam int unsigned STAGE_W = PC_W + INSTR_W;

  logic [PC_W-1:0]    pc_q;
  logic [PC_W-1:0]    pc_seq;
  logic [PC_W-1:0]    pc_next;
  logic [INSTR_W-1:0] rom_data;
  logic [STAGE_W-1:0] stage_q;
  npc_src_e           npc_src;
  logic               redirect;

  fetch_next_pc #(.PC_W(PC_W)) u_next_pc (
    .pc_i           (pc_q),
    .branch_taken_i (branch_taken_i),
    .branch_addr_i  (branch_addr_i),
    .jump_i         (jump_i),
    .jump_addr_i    (jump_addr_i),
    .pc_plus4_o     (pc_seq),
    .next_pc_o      (pc_next),
    .src_o          (npc_src)
  );

  assign redirect = (npc_src != NPC_SEQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (en_i) pc_q <= pc_next;
  end

  fetch_rom #(
    .PC_W      (PC_W),
    .ROM_WORDS (ROM_WORDS),
    .ROM_BASE  (ROM_BASE),
    .ROM_STEP  (ROM_STEP)
  ) u_rom (
    .word_idx_i (pc_q[PC_W-1:2]),
    .data_o     (rom_data)
  );

  fetch_dec_reg #(.WIDTH(STAGE_W)) u_if_id (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .flush_i (redirect),
    .d_i     ({pc_seq, rom_data}),
    .q_o     (stage_q)
  );

  assign pc_plus4_o = stage_q[STAGE_W-1:INSTR_W];
  assign instr_o    = stage_q[INSTR_W-1:0];
endmodule

// File: rtl/fetch_stage_chk.sv
module fetch_stage_chk #(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned INSTR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               branch_taken_i,
  input logic [PC_W-1:0]    branch_addr_i,
  input logic               jump_i,
  input logic [PC_W-1:0]    jump_addr_i,
  input logic [PC_W-1:0]    pc_q,
  input logic [PC_W-1:0]    pc_plus4_o,
  input logic [INSTR_W-1:0] instr_o
);
  AST_SEQ_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !branch_taken_i && !jump_i) |=>
      (pc_plus4_o == PC_W'($past(pc_q) + PC_W'(4))) && (pc_q == pc_plus4_o)); // R2

  AST_BRANCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && branch_taken_i && !jump_i) |=> (pc_q == $past(branch_addr_i))); // R3

  AST_JUMP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && jump_i) |=> (pc_q == $past(jump_addr_i))); // R4

  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_taken_i || jump_i) |=> (pc_plus4_o == '0) && (instr_o == '0)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !branch_taken_i && !jump_i) |=>
      $stable(pc_plus4_o) && $stable(instr_o) && $stable(pc_q)); // R6

  AST_STALL_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_q)); // R6
endmodule

bind fetch_stage fetch_stage_chk #(.PC_W(PC_W), .INSTR_W(32)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .branch_taken_i (branch_taken_i),
  .branch_addr_i  (branch_addr_i),
  .jump_i         (jump_i),
  .jump_addr_i    (jump_addr_i),
  .pc_q           (pc_q),
  .pc_plus4_o     (pc_plus4_o),
  .instr_o        (instr_o)
);

// File: tb/fetch_stage_bench.sv
`timescale 1ns/1ps
module fetch_stage_bench;
  localparam int unsigned PC_W      = 10;
  localparam int unsigned WORDS     = 12;
  localparam logic [31:0] BASE      = 32'h1357_0A00;
  localparam logic [31:0] STEP      = 32'h0101_0111;
  localparam int          NVEC      = 17;

  // {en, branch, jump, branch_addr[9:0], jump_addr[9:0]}
  localparam logic [22:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b1, 1'b0, 10'h020, 10'h000},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b0, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b0, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b1, 1'b1, 10'h010, 10'h100},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b0, 1'b0, 1'b1, 10'h000, 10'h3FC},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b0, 1'b1, 10'h000, 10'h3FC},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000},
    {1'b1, 1'b1, 1'b0, 10'h008, 10'h000},
    {1'b1, 1'b0, 1'b0, 10'h000, 10'h000}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic            branch_taken_i = 1'b0;
  logic [PC_W-1:0] branch_addr_i = '0;
  logic            jump_i = 1'b0;
  logic [PC_W-1:0] jump_addr_i = '0;
  logic [PC_W-1:0] pc_plus4_o;
  logic [31:0]     instr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [PC_W-1:0] m_pc;
  logic [PC_W-1:0] m_pc4;
  logic [31:0]     m_instr;

  always #5 clk_i = ~clk_i;

  fetch_stage #(
    .PC_W(PC_W), .ROM_WORDS(WORDS), .ROM_BASE(BASE), .ROM_STEP(STEP)
  ) u_fetch_stage (
    .clk_i, .rst_ni, .en_i, .branch_taken_i, .branch_addr_i,
    .jump_i, .jump_addr_i, .pc_plus4_o, .instr_o
  );

  function automatic logic [31:0] exp_word(input logic [PC_W-1:0] addr);
    int unsigned k;
    k = int'(addr[PC_W-1:2]);
    if (k < WORDS) return BASE + 32'(k) * STEP;
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [PC_W-1:0] e_pc4, input logic [31:0] e_ins);
    checks++;
    if (pc_plus4_o !== e_pc4 || instr_o !== e_ins) begin
      fails++;
      $display("FAIL %s: pc_plus4=%h instr=%h expected pc_plus4=%h instr=%h",
               req, pc_plus4_o, instr_o, e_pc4, e_ins);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    string tag;
    logic  flush;
    // R1: outputs zero while held in reset
    repeat (3) @(posedge clk_i);
    #1 check("R1", '0, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_pc = '0; m_pc4 = '0; m_instr = '0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      en_i           = VECS[i][22];
      branch_taken_i = VECS[i][21];
      jump_i         = VECS[i][20];
      branch_addr_i  = VECS[i][19:10];
      jump_addr_i    = VECS[i][9:0];
      flush = branch_taken_i | jump_i;
      if (flush) begin
        m_pc4 = '0; m_instr = '0;
      end else if (en_i) begin
        m_pc4 = m_pc + PC_W'(4); m_instr = exp_word(m_pc);
      end
      if (en_i) m_pc = jump_i ? jump_addr_i : (branch_taken_i ? branch_addr_i : m_pc + PC_W'(4));
      if (jump_i && branch_taken_i) tag = "R4";
      else if (flush)               tag = "R5";
      else if (!en_i)               tag = "R6";
      else if (m_pc4 == '0)         tag = "R8";
      else if (m_instr == '0)       tag = "R7";
      else                          tag = "R2";
      @(posedge clk_i);
      #1 check(tag, m_pc4, m_instr);
      // after a redirect, the next clean fetch shows the target (R3 / R4)
      if (i == 4)  check("R3", 10'h024, exp_word(10'h020));
      if (i == 9)  check("R4", 10'h104, 32'h0);
    end

    // R1: asynchronous reset mid-cycle clears without a clock edge
    @(negedge clk_i);
    en_i = 1'b1; branch_taken_i = 1'b0; jump_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1 check("R1", '0, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1 check("R1", 10'h004, BASE);
    @(posedge clk_i);
    #1 check("R7", 10'h008, BASE + STEP);

    done = 1'b1;
    finish_run();
  end
endmodule